// File: doc/BRIEF.md
# Carry-Skip Block Adder

This block adds two unsigned binary operands and a carry-in, producing a sum of the same width and a carry-out. The operand width is split into equal groups, four bits each by default. Each group works out per-bit propagate, generate and kill terms and passes its carry from bit to bit. A group whose bits all propagate also has a skip multiplexer, which hands the group's carry-in straight to its carry-out. With this structure the long carry path runs through the lowest group's chain, then the skip multiplexers of the middle groups, then the chain of the top group, instead of through every bit.

The adder logic is combinational. Its result is captured in an output register that has a synchronous, active-high reset. A result therefore appears on the outputs one clock edge after the operands are presented. The operand width and the group width are parameters, and the group width must divide the operand width evenly.

Top module: `csk_adder`

## Requirements
- R1: On a rising clock edge with `rst` high, `sum_o` and `cout_o` become 0, whatever the operand inputs are.
- R2: With `rst` low, the values on `sum_o` and `cout_o` after a rising edge are computed from the inputs present at that edge, so inputs that change every cycle give a matching result every cycle.
- R3: `{cout_o, sum_o}` equals the unsigned sum `a_i + b_i + cin_i`, reduced modulo 2^(WIDTH+1).
- R4: When every bit propagates (`a_i == ~b_i`), the result with `cin_i` = 0 is `sum_o` all ones and `cout_o` = 0. With `cin_i` = 1 it is `sum_o` = 0 and `cout_o` = 1.
- R5: The carry-out that a group's skip multiplexer produces always equals the carry leaving the end of that group's own chain. The sum bits of the group above use that carry, whether it was skipped or passed along the chain.
- R6: A carry generated in bit 0, with every higher bit propagating (`a_i` = 1, `b_i` all ones, `cin_i` = 0), gives `sum_o` = 0 and `cout_o` = 1.
- R7: When every bit kills (both operands 0), `cin_i` reaches only bit 0 (`sum_o` = `cin_i`, `cout_o` = 0). When every bit generates (both operands all ones), the result is `sum_o` = all ones with bit 0 equal to `cin_i`, and `cout_o` = 1.
- R8: A narrow configuration (6-bit operands, 2-bit groups) gives the result R3 states for every combination of its operands and carry-in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge captures the result |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry-in to bit 0 |
| sum_o | output | WIDTH | Registered sum |
| cout_o | output | 1 | Registered carry-out of the top group |

## Verification
The hardest case to reach from the ports is a carry that actually takes the skip multiplexer. A group has to propagate on every bit while a real carry arrives from the group below. The carry must then go on through further groups, and random operands rarely give that. Directed vectors build it on purpose: operands that are complements of each other, with both carry-in values; a carry generated in bit 0 that travels to the top; and one all-propagate group placed above a group that generates. The exhaustive run on the narrow configuration reaches every skip and chain combination of its groups.

// File: rtl/csk_pkg.sv
package csk_pkg;
  // Per-bit carry terms
  typedef struct packed {
    logic p;  // propagate: exactly one operand bit set
    logic g;  // generate: both operand bits set
    logic k;  // kill: neither operand bit set
  } pg_t;
endpackage

// File: rtl/csk_pg_cell.sv
module csk_pg_cell (
  input  logic         a_i,
  input  logic         b_i,
  output csk_pkg::pg_t pg_o
);
  assign pg_o.p = a_i ^ b_i;
  assign pg_o.g = a_i & b_i;
  assign pg_o.k = ~a_i & ~b_i;
endmodule

// File: rtl/csk_group.sv
module csk_group #(
  parameter int GW = 4
) (
  input  logic [GW-1:0] a_i,
  input  logic [GW-1:0] b_i,
  input  logic          cin_i,
  output logic [GW-1:0] sum_o,
  output logic          cout_o,
  output logic          ripple_o
);
  csk_pkg::pg_t      pg [GW];
  logic [GW:0]       chain;
  logic [GW-1:0]     pvec;
  logic              skip;

  assign chain[0] = cin_i;

  for (genvar i = 0; i < GW; i++) begin : g_bit
    csk_pg_cell u_cell (
      .a_i  (a_i[i]),
      .b_i  (b_i[i]),
      .pg_o (pg[i])
    );
    // carry leaves bit i when generated, or when it arrives and is not killed
    assign chain[i+1] = pg[i].g | (chain[i] & ~pg[i].k);
    assign sum_o[i]   = pg[i].p ^ chain[i];
    assign pvec[i]    = pg[i].p;
  end

  assign skip     = &pvec;
  assign ripple_o = chain[GW];
  assign cout_o   = skip ? cin_i : chain[GW];
endmodule

// File: rtl/csk_core.sv
module csk_core #(
  parameter int WIDTH = 16,
  parameter int GW    = 4,
  localparam int NG   = WIDTH / GW
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic [NG-1:0]    grp_cout_o,
  output logic [NG-1:0]    grp_ripple_o
);
  if (WIDTH % GW != 0) begin : g_bad_cfg
    $error("csk_core: group width must divide operand width");
  end

  logic [NG:0] gcar;
  assign gcar[0] = cin_i;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    csk_group #(.GW(GW)) u_grp (
      .a_i      (a_i[g*GW +: GW]),
      .b_i      (b_i[g*GW +: GW]),
      .cin_i    (gcar[g]),
      .sum_o    (sum_o[g*GW +: GW]),
      .cout_o   (gcar[g+1]),
      .ripple_o (grp_ripple_o[g])
    );
  end

  assign grp_cout_o = gcar[NG:1];
  assign cout_o     = gcar[NG];
endmodule

// File: rtl/csk_adder.sv
module csk_adder #(
  parameter int WIDTH   = 16,
  parameter int GROUP_W = 4,
  localparam int NGRP   = WIDTH / GROUP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic [WIDTH-1:0] sum_c;
  logic             cout_c;
  logic [NGRP-1:0]  grp_cout;
  logic [NGRP-1:0]  grp_ripple;

  csk_core #(.WIDTH(WIDTH), .GW(GROUP_W)) u_core (
    .a_i          (a_i),
    .b_i          (b_i),
    .cin_i        (cin_i),
    .sum_o        (sum_c),
    .cout_o       (cout_c),
    .grp_cout_o   (grp_cout),
    .grp_ripple_o (grp_ripple)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_o  <= '0;
      cout_o <= 1'b0;
    end else begin
      sum_o  <= sum_c;
      cout_o <= cout_c;
    end
  end
endmodule

// File: rtl/csk_adder_chk.sv
module csk_adder_chk #(
  parameter int WIDTH = 16,
  parameter int NGRP  = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o,
  input logic [NGRP-1:0]  grp_cout,
  input logic [NGRP-1:0]  grp_ripple
);
  logic [WIDTH:0] ref_total;
  assign ref_total = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

  // R1
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (sum_o == '0 && !cout_o));

  // R2, R3
  assert_sum_matches_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ({cout_o, sum_o} == $past(ref_total)));

  // R4
  assert_all_propagate_R4: assert property (@(posedge clk) disable iff (rst)
    (a_i == ~b_i) |=> (sum_o == {WIDTH{~$past(cin_i)}} && cout_o == $past(cin_i)));

  // R5
  assert_skip_agrees_R5: assert property (@(posedge clk) disable iff (rst)
    grp_cout == grp_ripple);

  // R7
  assert_all_kill_R7: assert property (@(posedge clk) disable iff (rst)
    (a_i == '0 && b_i == '0) |=> (!cout_o && $countones(sum_o) == int'($past(cin_i))));
endmodule

bind csk_adder csk_adder_chk #(.WIDTH(WIDTH), .NGRP(NGRP)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .a_i        (a_i),
  .b_i        (b_i),
  .cin_i      (cin_i),
  .sum_o      (sum_o),
  .cout_o     (cout_o),
  .grp_cout   (grp_cout),
  .grp_ripple (grp_ripple)
);

// File: tb/csk_adder_tb.sv
module csk_adder_tb;
  localparam int W  = 16;
  localparam int NW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  a = '0, b = '0;
  logic          cin = 1'b0;
  logic [W-1:0]  sum;
  logic          cout;
  logic [NW-1:0] na = '0, nb = '0;
  logic          ncin = 1'b0;
  logic [NW-1:0] nsum;
  logic          ncout;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  csk_adder #(.WIDTH(W), .GROUP_W(4)) u_dut (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .cin_i(cin),
    .sum_o(sum), .cout_o(cout)
  );

  csk_adder #(.WIDTH(NW), .GROUP_W(2)) u_dut_narrow (
    .clk(clk), .rst(rst), .a_i(na), .b_i(nb), .cin_i(ncin),
    .sum_o(nsum), .cout_o(ncout)
  );

  task automatic chk(input string req, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at a falling edge, result registered at the next rising edge,
  // sampled at the following falling edge
  task automatic add_check(input string req, input logic [W-1:0] x,
                           input logic [W-1:0] y, input logic c);
    @(negedge clk);
    a = x; b = y; cin = c;
    @(negedge clk);
    chk(req, {cout, sum}, {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c});
  endtask

  task automatic t_reset;  // R1
    @(negedge clk);
    rst = 1'b1; a = 16'h1234; b = 16'hF0F0; cin = 1'b1;
    @(negedge clk);
    chk("R1 reset clears", {cout, sum}, '0);
    chk("R1 reset clears narrow", {{(W-NW){1'b0}}, ncout, nsum}, '0);
    rst = 1'b0;
  endtask

  task automatic t_back_to_back;  // R2: new operands every cycle
    logic [W:0] exp_prev;
    @(negedge clk);
    a = 16'h0F0F; b = 16'h0101; cin = 1'b0;
    exp_prev = 17'h0F0F + 17'h0101;
    for (int i = 0; i < 20; i++) begin
      logic [W-1:0] x, y;
      x = W'($urandom); y = W'($urandom);
      @(negedge clk);
      chk("R2 per-cycle result", {cout, sum}, exp_prev);
      a = x; b = y; cin = i[0];
      exp_prev = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, i[0]};
    end
    @(negedge clk);
    chk("R2 per-cycle result", {cout, sum}, exp_prev);
  endtask

  task automatic t_random;  // R3
    for (int i = 0; i < 600; i++)
      add_check("R3 random", W'($urandom), W'($urandom), 1'($urandom));
  endtask

  task automatic t_all_propagate;  // R4
    add_check("R4 a=~b cin0", 16'h5A3C, 16'hA5C3, 1'b0);
    chk("R4 sum all ones", {cout, sum}, {1'b0, 16'hFFFF});
    add_check("R4 a=~b cin1", 16'h5A3C, 16'hA5C3, 1'b1);
    chk("R4 wraps to zero", {cout, sum}, {1'b1, 16'h0000});
    add_check("R4 a=~b cin1", 16'h0000, 16'hFFFF, 1'b1);
  endtask

  task automatic t_skip_carry;  // R5: carry enters an all-propagate group
    add_check("R5 gen g0, skip g1", 16'h00AF, 16'h0051, 1'b0);
    add_check("R5 gen g0, skip g1 g2", 16'h0A5F, 16'h05A1, 1'b0);
    add_check("R5 skip g1 only, cin", 16'h12A3, 16'h0450, 1'b1);
    add_check("R5 gen g2, skip g3", 16'h5800, 16'hA800, 1'b0);
  endtask

  task automatic t_long_carry;  // R6
    add_check("R6 bit0 carry to top", 16'h0001, 16'hFFFF, 1'b0);
    chk("R6 exact value", {cout, sum}, {1'b1, 16'h0000});
  endtask

  task automatic t_kill_gen;  // R7
    add_check("R7 all kill cin1", 16'h0000, 16'h0000, 1'b1);
    chk("R7 all kill value", {cout, sum}, 17'h00001);
    add_check("R7 all generate cin1", 16'hFFFF, 16'hFFFF, 1'b1);
    chk("R7 all generate value", {cout, sum}, {1'b1, 16'hFFFF});
    add_check("R7 all generate cin0", 16'hFFFF, 16'hFFFF, 1'b0);
  endtask

  task automatic t_narrow_exhaustive;  // R8
    int bad = 0;
    for (int x = 0; x < 64; x++)
      for (int y = 0; y < 64; y++)
        for (int c = 0; c < 2; c++) begin
          logic [NW:0] exp_n;
          @(negedge clk);
          na = NW'(x); nb = NW'(y); ncin = 1'(c);
          exp_n = (NW+1)'(x) + (NW+1)'(y) + (NW+1)'(c);
          @(negedge clk);
          checks++;
          if ({ncout, nsum} !== exp_n) begin
            fails++; bad++;
            if (bad < 10)
              $display("FAIL R8 narrow %0d+%0d+%0d: actual %h expected %h",
                       x, y, c, {ncout, nsum}, exp_n);
          end
        end
  endtask

  initial begin
    #(4 * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_back_to_back();
    t_all_propagate();
    t_skip_carry();
    t_long_carry();
    t_kill_gen();
    t_random();
    t_narrow_exhaustive();
    add_check("R1 pre-reset value", 16'h8000, 16'h8000, 1'b1);
    t_reset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule